// File: doc/BRIEF.md
# LED Print Head Line Streamer

This block feeds one raster line of bitmap data into a serial LED print head and then fires it. Bytes arrive from a line buffer over a valid/ready handshake. Each byte is shifted out most significant bit first on a single data pin, with a generated head clock. The first bit shifted is the one for the highest-numbered dot. Once the last dot is shifted, the block raises a latch pulse that moves the line into the head's output latches. It then pulses four active-low strobes one after another. Each strobe lights one quarter of the dot row: dots 1 to 640, 641 to 1280, 1281 to 1920 and 1921 to 2560 for a full-length head.

A page sync pulse arms the block, and each line sync pulse starts one line. The nominal line period is a few milliseconds, far longer than one streamed line. Two head variants are supported: a full line (2560 dots by default) and a shorter line (2496 dots by default), selected per line. The strobe pulse width comes from a width input that is captured at line start. Two sticky flags report trouble. The underrun flag is set when the buffer cannot supply a byte when one is needed. The overrun flag is set when a line sync arrives while a line is still being processed.

Top module: `led_line_streamer`

## Requirements
- R1: Each byte is shifted most significant bit first, one bit per head clock period of 2*HALF_DIV cycles. For each bit, head_data_o holds the bit for the whole period, and head_clk_o is low for the first HALF_DIV cycles and high for the last HALF_DIV cycles. Outside a bit period both pins are low.
- R2: A line has DOTS_ALT bits when short_line_i is 1 at line start and DOTS_FULL bits otherwise, so head_clk_o rises exactly that many times per line. Both lengths are multiples of 8.
- R3: In the cycle after the last bit period ends, head_latch_o goes high for LATCH_CYC cycles, and no strobe is low during that time.
- R4: After the latch, the strobes fire in the order head_strobe_no[0], [1], [2], [3]. Each one is low for strobe_width_i+1 cycles, using the width captured at line start, and is followed by STB_GAP cycles with all strobes high. At most one strobe is low in any cycle.
- R5: line_sync_i has no effect until a page_sync_i pulse has armed the block. When the block is armed and idle, a line sync starts a line, and busy_o is high from the next cycle until the last strobe gap cycle. After that the block returns to armed idle.
- R6: byte_ready_o is high only while a line is shifting and a new byte is needed: at line start and after every 8 bits. One byte is taken per handshake, and it is taken in the cycle in which byte_valid_i and byte_ready_o are both high.
- R7: A cycle with byte_ready_o high and byte_valid_i low sets underrun_o from the next cycle on. Shifting stalls, with head_clk_o low, until a byte is supplied.
- R8: A line sync that arrives while busy_o is high does not restart or change the current line, and it sets overrun_o from the next cycle on. This includes a sync that arrives on the last strobe gap cycle.
- R9: After reset all strobes are high, the latch, head clock, data, byte_ready_o, busy_o and both flags are low, and the block is not armed. A page sync clears both sticky flags, and they read 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| page_sync_i | input | 1 | Page start pulse; arms the block and clears the flags |
| line_sync_i | input | 1 | Line start pulse |
| short_line_i | input | 1 | Selects the short head length for the next line |
| strobe_width_i | input | SW_W | Strobe low time minus one, in cycles |
| byte_data_i | input | 8 | Bitmap byte from the line buffer |
| byte_valid_i | input | 1 | Byte available |
| byte_ready_o | output | 1 | Byte requested |
| head_clk_o | output | 1 | Head shift clock |
| head_data_o | output | 1 | Serial dot data |
| head_latch_o | output | 1 | Head latch pulse |
| head_strobe_no | output | 4 | Active-low quarter strobes |
| busy_o | output | 1 | Line in progress |
| underrun_o | output | 1 | Sticky: byte missing when needed |
| overrun_o | output | 1 | Sticky: line sync while busy |

## Verification
The case that matters most is a line sync arriving in the same cycle that the firing sequence finishes. The bench drives line_sync_i during the final strobe gap cycle of one line and again in the very next cycle. It expects the first sync to be treated as an overrun, with no restart of the line. It expects the second sync to start a fresh line with the correct bit count. A per-cycle reference trace also places a line sync in the middle of shifting, and it stalls the byte stream in the middle of a line. This shows that an overrun and an underrun each leave the serial stream intact.

// File: rtl/lls_pkg.sv
package lls_pkg;
  localparam int BYTE_W = 8;
  localparam int GROUPS = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_LINE
  } line_state_e;

  typedef enum logic [1:0] {
    FI_IDLE,
    FI_LATCH,
    FI_ON,
    FI_GAP
  } fire_state_e;
endpackage

// File: rtl/lls_bit_timer.sv
module lls_bit_timer #(
  parameter int HALF_DIV = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic clk_lvl_o,
  output logic bit_end_o
);
  localparam int PH_W = (2 * HALF_DIV > 1) ? $clog2(2 * HALF_DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * HALF_DIV - 1);
  localparam logic [PH_W-1:0] PH_HIGH = PH_W'(HALF_DIV);

  logic [PH_W-1:0] phase_q;

  assign clk_lvl_o = run_i && (phase_q >= PH_HIGH);
  assign bit_end_o = run_i && (phase_q == PH_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else if (run_i) phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
  end

  // R1: a bit period closes in the high half of the head clock
  a_r1_end_in_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_end_o |-> clk_lvl_o);
endmodule

// File: rtl/lls_serializer.sv
module lls_serializer #(
  parameter int DOTS_FULL = 2560,
  parameter int DOTS_ALT  = 2496,
  parameter int HALF_DIV  = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      short_i,
  input  logic [lls_pkg::BYTE_W-1:0] byte_data_i,
  input  logic                      byte_valid_i,
  output logic                      byte_ready_o,
  output logic                      head_clk_o,
  output logic                      head_data_o,
  output logic                      underrun_o,
  output logic                      done_o
);
  localparam int BW    = lls_pkg::BYTE_W;
  localparam int DOT_W = $clog2(DOTS_FULL + 1);
  localparam int LFT_W = $clog2(BW + 1);

  logic             active_q;
  logic [BW-1:0]    sreg_q;
  logic [LFT_W-1:0] left_q;
  logic [DOT_W-1:0] dots_q;
  logic             run, bit_end;

  assign run = active_q && (left_q != '0);

  lls_bit_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .clk_lvl_o (head_clk_o),
    .bit_end_o (bit_end)
  );

  assign byte_ready_o = active_q && (left_q == '0);
  assign underrun_o   = byte_ready_o && !byte_valid_i;
  assign done_o       = bit_end && (dots_q == DOT_W'(1));
  assign head_data_o  = run && sreg_q[BW-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sreg_q   <= '0;
      left_q   <= '0;
      dots_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      left_q   <= '0;
      dots_q   <= short_i ? DOT_W'(DOTS_ALT) : DOT_W'(DOTS_FULL);
    end else if (byte_ready_o && byte_valid_i) begin
      sreg_q <= byte_data_i;
      left_q <= LFT_W'(BW);
    end else if (bit_end) begin
      sreg_q <= {sreg_q[BW-2:0], 1'b0};
      left_q <= left_q - 1'b1;
      dots_q <= dots_q - 1'b1;
      if (dots_q == DOT_W'(1)) active_q <= 1'b0;
    end
  end

  // R6: no head clock while waiting for a byte
  a_r6_ready_no_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ready_o |-> !head_clk_o);
  // R6: a handshake satisfies the request
  a_r6_load_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_ready_o && byte_valid_i) |=> !byte_ready_o);
  // R1: data held while head clock is high
  a_r1_data_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (head_clk_o && $past(head_clk_o)) |-> $stable(head_data_o));
endmodule

// File: rtl/lls_fire_seq.sv
module lls_fire_seq #(
  parameter int LATCH_CYC = 10,
  parameter int STB_GAP   = 10,
  parameter int SW_W      = 12
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [SW_W-1:0]            width_i,
  output logic                       latch_o,
  output logic [lls_pkg::GROUPS-1:0] strobe_no,
  output logic                       done_o
);
  import lls_pkg::*;
  localparam int LW    = $clog2(LATCH_CYC + 1);
  localparam int GW    = $clog2(STB_GAP + 1);
  localparam int MW    = (LW > GW) ? LW : GW;
  localparam int CNT_W = (SW_W > MW) ? SW_W : MW;
  localparam int GRP_W = $clog2(GROUPS);

  fire_state_e      st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [GRP_W-1:0] grp_q;
  logic             on;

  assign latch_o = (st_q == FI_LATCH);
  assign on      = (st_q == FI_ON);
  assign done_o  = (st_q == FI_GAP) && (cnt_q == CNT_W'(STB_GAP - 1)) &&
                   (grp_q == GRP_W'(GROUPS - 1));

  for (genvar g = 0; g < GROUPS; g++) begin : g_stb
    assign strobe_no[g] = !(on && (grp_q == GRP_W'(g)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= FI_IDLE;
      cnt_q <= '0;
      grp_q <= '0;
    end else begin
      unique case (st_q)
        FI_IDLE: if (start_i) begin
          st_q  <= FI_LATCH;
          cnt_q <= '0;
        end
        FI_LATCH: begin
          if (cnt_q == CNT_W'(LATCH_CYC - 1)) begin
            st_q  <= FI_ON;
            cnt_q <= '0;
            grp_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        FI_ON: begin
          if (cnt_q == CNT_W'(width_i)) begin
            st_q  <= FI_GAP;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        FI_GAP: begin
          if (cnt_q == CNT_W'(STB_GAP - 1)) begin
            cnt_q <= '0;
            if (grp_q == GRP_W'(GROUPS - 1)) st_q <= FI_IDLE;
            else begin
              grp_q <= grp_q + 1'b1;
              st_q  <= FI_ON;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= FI_IDLE;
      endcase
    end
  end

  // R4: never two strobes at once
  a_r4_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~strobe_no));
  // R3: latch and strobes never overlap
  a_r3_latch_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |-> (&strobe_no));
  // R4: first quarter fires right after the latch
  a_r4_first_after_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(latch_o) |-> !strobe_no[0]);
endmodule

// File: rtl/led_line_streamer.sv
module led_line_streamer #(
  parameter int DOTS_FULL = 2560,
  parameter int DOTS_ALT  = 2496,
  parameter int HALF_DIV  = 5,
  parameter int LATCH_CYC = 10,
  parameter int STB_GAP   = 10,
  parameter int SW_W      = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            page_sync_i,
  input  logic            line_sync_i,
  input  logic            short_line_i,
  input  logic [SW_W-1:0] strobe_width_i,
  input  logic [7:0]      byte_data_i,
  input  logic            byte_valid_i,
  output logic            byte_ready_o,
  output logic            head_clk_o,
  output logic            head_data_o,
  output logic            head_latch_o,
  output logic [3:0]      head_strobe_no,
  output logic            busy_o,
  output logic            underrun_o,
  output logic            overrun_o
);
  import lls_pkg::*;

  line_state_e     st_q;
  logic [SW_W-1:0] width_q;
  logic            und_q, ovr_q;
  logic            line_go, ser_done, ser_und, fire_done, ovr_set;

  assign line_go = (st_q == ST_ARMED) && line_sync_i;
  assign ovr_set = (st_q == ST_LINE) && line_sync_i;
  assign busy_o     = (st_q == ST_LINE);
  assign underrun_o = und_q;
  assign overrun_o  = ovr_q;

  lls_serializer #(
    .DOTS_FULL (DOTS_FULL),
    .DOTS_ALT  (DOTS_ALT),
    .HALF_DIV  (HALF_DIV)
  ) u_ser (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (line_go),
    .short_i      (short_line_i),
    .byte_data_i  (byte_data_i),
    .byte_valid_i (byte_valid_i),
    .byte_ready_o (byte_ready_o),
    .head_clk_o   (head_clk_o),
    .head_data_o  (head_data_o),
    .underrun_o   (ser_und),
    .done_o       (ser_done)
  );

  lls_fire_seq #(
    .LATCH_CYC (LATCH_CYC),
    .STB_GAP   (STB_GAP),
    .SW_W      (SW_W)
  ) u_fire (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (ser_done),
    .width_i   (width_q),
    .latch_o   (head_latch_o),
    .strobe_no (head_strobe_no),
    .done_o    (fire_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      width_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE:  if (page_sync_i) st_q <= ST_ARMED;
        ST_ARMED: if (line_go) begin
          st_q    <= ST_LINE;
          width_q <= strobe_width_i;
        end
        ST_LINE:  if (fire_done) st_q <= ST_ARMED;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  // sticky flags: a set in the same cycle as a page sync wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      und_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      und_q <= ser_und || (und_q && !page_sync_i);
      ovr_q <= ovr_set || (ovr_q && !page_sync_i);
    end
  end

  // R8: sync during a line is recorded
  a_r8_overrun_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && line_sync_i) |=> overrun_o);
  // R8: overrun holds until page sync
  a_r8_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !page_sync_i) |=> overrun_o);
  // R7: underrun holds until page sync
  a_r7_underrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_o && !page_sync_i) |=> underrun_o);
  // R7: a missing byte is recorded
  a_r7_underrun_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_ready_o && !byte_valid_i) |=> underrun_o);
  // R5: nothing requested while not busy
  a_r5_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!byte_ready_o && !head_clk_o && !head_latch_o));
endmodule

// File: tb/led_line_streamer_tb_top.sv
module led_line_streamer_tb_top;
  localparam int DF  = 32;
  localparam int DA  = 24;
  localparam int HD  = 2;
  localparam int LC  = 3;
  localparam int SG  = 2;
  localparam int SWW = 4;

  logic           clk_i = 1'b0;
  logic           rst_ni;
  logic           page_sync_i, line_sync_i, short_line_i;
  logic [SWW-1:0] strobe_width_i;
  logic [7:0]     byte_data_i;
  logic           byte_valid_i;
  logic           byte_ready_o, head_clk_o, head_data_o, head_latch_o;
  logic [3:0]     head_strobe_no;
  logic           busy_o, underrun_o, overrun_o;

  always #10 clk_i = ~clk_i;

  led_line_streamer #(
    .DOTS_FULL (DF), .DOTS_ALT (DA), .HALF_DIV (HD),
    .LATCH_CYC (LC), .STB_GAP (SG), .SW_W (SWW)
  ) dut_i (
    .clk_i, .rst_ni, .page_sync_i, .line_sync_i, .short_line_i,
    .strobe_width_i, .byte_data_i, .byte_valid_i, .byte_ready_o,
    .head_clk_o, .head_data_o, .head_latch_o, .head_strobe_no,
    .busy_o, .underrun_o, .overrun_o
  );

  typedef struct {
    bit       e_clk, e_data, e_latch, e_ready, e_busy;
    bit [3:0] e_stb;
    bit       d_valid;
    bit [7:0] d_byte;
    bit       d_sync, d_page;
  } ent_t;

  ent_t tq[$];
  int   n_chk = 0, n_fail = 0;
  bit   exp_und = 0, exp_ovr = 0;
  bit   finished = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic ent_t mk(bit busy);
    ent_t e;
    e = '{default: 0};
    e.e_stb  = 4'hF;
    e.e_busy = busy;
    return e;
  endfunction

  task automatic push_idle(int n);
    for (int i = 0; i < n; i++) tq.push_back(mk(0));
  endtask

  task automatic push_sync();
    ent_t e;
    e = mk(0);
    e.d_sync = 1;
    tq.push_back(e);
  endtask

  // expected trace of one line from the cycle after its line sync
  task automatic build_line(int nb, int base, int stall_b, int stall_n, int w,
                            int ovr_idx, bit sync_last);
    ent_t e;
    int start;
    logic [7:0] b;
    start = tq.size();
    for (int i = 0; i < nb; i++) begin
      b = 8'(base + i * 53);
      if (i == stall_b)
        for (int s = 0; s < stall_n; s++) begin
          e = mk(1); e.e_ready = 1; tq.push_back(e);
        end
      e = mk(1); e.e_ready = 1; e.d_valid = 1; e.d_byte = b; tq.push_back(e);
      for (int j = 7; j >= 0; j--)
        for (int p = 0; p < 2 * HD; p++) begin
          e = mk(1); e.e_data = b[j]; e.e_clk = (p >= HD); tq.push_back(e);
        end
    end
    for (int i = 0; i < LC; i++) begin
      e = mk(1); e.e_latch = 1; tq.push_back(e);
    end
    for (int g = 0; g < 4; g++) begin
      for (int i = 0; i <= w; i++) begin
        e = mk(1); e.e_stb = ~(4'b0001 << g); tq.push_back(e);
      end
      for (int i = 0; i < SG; i++) tq.push_back(mk(1));
    end
    if (ovr_idx >= 0) begin
      e = tq[start + ovr_idx]; e.d_sync = 1; tq[start + ovr_idx] = e;
    end
    if (sync_last) begin
      e = tq[tq.size() - 1]; e.d_sync = 1; tq[tq.size() - 1] = e;
    end
  endtask

  task automatic run_queue(output int rises);
    ent_t e;
    bit prev;
    prev  = 0;
    rises = 0;
    while (tq.size() > 0) begin
      @(negedge clk_i);
      e = tq.pop_front();
      chk("R1 head_clk", head_clk_o, e.e_clk);
      chk("R1 head_data", head_data_o, e.e_data);
      chk("R3 latch", head_latch_o, e.e_latch);
      chk("R4 strobes", head_strobe_no, e.e_stb);
      chk("R6 byte_ready", byte_ready_o, e.e_ready);
      chk("R5 busy", busy_o, e.e_busy);
      chk("R7 underrun", underrun_o, exp_und);
      chk("R8 overrun", overrun_o, exp_ovr);
      if (head_clk_o && !prev) rises++;
      prev = head_clk_o;
      byte_valid_i = e.d_valid;
      byte_data_i  = e.d_byte;
      line_sync_i  = e.d_sync;
      page_sync_i  = e.d_page;
      if (e.d_page) begin exp_und = 0; exp_ovr = 0; end
      if (e.d_sync && e.e_busy) exp_ovr = 1;
      if (e.e_ready && !e.d_valid) exp_und = 1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int r;
    ent_t e;
    rst_ni = 0; page_sync_i = 0; line_sync_i = 0; short_line_i = 0;
    strobe_width_i = '0; byte_data_i = '0; byte_valid_i = 0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1;

    // R9 reset state
    chk("R9 reset strobes", head_strobe_no, 4'hF);
    chk("R9 reset latch", head_latch_o, 0);
    chk("R9 reset ready", byte_ready_o, 0);
    chk("R9 reset busy", busy_o, 0);
    chk("R9 reset flags", {underrun_o, overrun_o}, 0);

    // R5: line sync before any page sync is ignored
    push_sync();
    push_idle(6);
    run_queue(r);
    chk("R5 unarmed rises", r, 0);

    // arm with a page sync
    e = mk(0); e.d_page = 1; tq.push_back(e);
    push_idle(2);
    run_queue(r);

    // R2: full line, width 3
    short_line_i = 0; strobe_width_i = 3;
    push_sync();
    build_line(DF / 8, 8'hA5, -1, 0, 3, -1, 0);
    push_idle(3);
    run_queue(r);
    chk("R2 full line rises", r, DF);

    // R2: short line, width 0
    short_line_i = 1; strobe_width_i = 0;
    push_sync();
    build_line(DA / 8, 8'h3C, -1, 0, 0, -1, 0);
    push_idle(3);
    run_queue(r);
    chk("R2 short line rises", r, DA);

    // R7: stall before byte 2
    short_line_i = 0; strobe_width_i = 1;
    push_sync();
    build_line(DF / 8, 8'h0F, 2, 3, 1, -1, 0);
    push_idle(2);
    run_queue(r);
    chk("R7 underrun line rises", r, DF);
    chk("R7 underrun sticky", underrun_o, 1);

    // R9: page sync clears flags
    e = mk(0); e.d_page = 1; tq.push_back(e);
    push_idle(2);
    run_queue(r);
    chk("R9 flags cleared", {underrun_o, overrun_o}, 0);

    // R8: sync mid-shift and on the final gap cycle, then sync one cycle later
    strobe_width_i = 2;
    push_sync();
    build_line(DF / 8, 8'h81, -1, 0, 2, 10, 1);
    push_sync();
    build_line(DF / 8, 8'h5A, -1, 0, 2, -1, 0);
    push_idle(3);
    run_queue(r);
    chk("R8 back-to-back rises", r, 2 * DF);
    chk("R8 overrun sticky", overrun_o, 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule